// File: doc/BRIEF.md
# Performance Counter Permission Filter

This block decides, every cycle, which event counters of a performance counter bank may count and whether the cycle counter may count. It does not count anything itself. Its count-enable outputs drive the increment qualifiers of an external counter bank.

The decision uses three inputs: the current exception level (0 to 3, where 3 is the monitor level and 2 is the hypervisor level), a secure-state flag, and a set of control fields. The control fields live in four small registers that are written through one write port. These are a monitor register, a hypervisor register, a user control register and a per-counter mask register.

A programmable split point divides the counters into two groups. The low group holds the counters whose index is below the split point. The high group holds the rest. The hypervisor rules treat each group differently, and one monitor-level mode also treats them differently.

The outputs are combinational functions of the stored fields and the current level and secure flag. A register write therefore takes effect in the cycle after its write edge.

Top module: `perf_cnt_gate`

## Requirements
- R1: After reset, every control field reads as zero except the split point, which equals NCNT. All enables are low until software writes a setting.
- R2: Register select 2 holds the run bit at bit 0 and the cycle-tie bit at bit 1. While run is 0, every bit of `evt_en` and `cyc_en` is 0.
- R3: Register select 3 holds one mask bit per counter at bits [NCNT-1:0]. Counter i can be enabled only while its mask bit is 1.
- R4: Register select 0 holds secure-allow at bit 0 and monitor-split at bit 1. When `in_secure`=1 and `cur_el` is below 3, event counting is prohibited for all counters unless at least one of these two bits is 1.
- R5: At `cur_el`=3, {secure-allow, monitor-split} selects the event counting rule:
  - 00 prohibits all counters.
  - 01 prohibits all counters.
  - 10 permits all counters.
  - 11 prohibits only the counters whose index is below the split point.
- R6: Register select 1 holds the split point at bits [4:0] and high-enable at bit 8. Both the split point and the counter index are compared as unsigned values. A counter whose index is at or above the split point counts only while high-enable is 1, at every level. A split point of 0 puts every counter in the high group.
- R7: Hypervisor-low-off is at bit 9 of register 1. While it is 1 and `cur_el`=2, counters below the split point are prohibited.
- R8: The cycle counter is prohibited in three cases:
  - at `cur_el`=3 when monitor-cycle-off (register 0 bit 2) is 1;
  - whenever `in_secure`=1 and secure-cycle-off (register 0 bit 3) is 1;
  - at `cur_el`=2 when hypervisor-cycle-off (register 1 bit 10) is 1.
- R9: While the cycle-tie bit is 1, the cycle counter stops whenever the current state prohibits a low-group counter, as defined by the R4, R5 and R7 rules. In particular, it stops at `cur_el`=3 unless the encoding is 10.
- R10: A write with `cfg_we`=1 loads `cfg_wdata` into the register chosen by `cfg_sel`, where 0 is monitor, 1 is hypervisor, 2 is user control and 3 is mask. The new value takes effect in the cycle after the write edge. The other registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 monitor, 1 hypervisor, 2 user, 3 mask) |
| cfg_wdata | input | DW | Write data |
| cur_el | input | 2 | Current exception level |
| in_secure | input | 1 | Current secure-state flag |
| evt_en | output | NCNT | Per-counter event count enables |
| cyc_en | output | 1 | Cycle counter enable |

## Verification
The outputs depend only on the stored fields and on the current level and secure flag. A wrong stored bit or a wrong split compare therefore shows up in the cycle right after the write that exposes it, as soon as the bench presents a matching level and secure flag. The bench varies the level and secure flag across many stored settings, so a field that latched into the wrong position shows up as a wrong enable pattern within a few cycles. The directed cases force each split-point boundary and each monitor encoding. This makes an off-by-one in the compare, or a swapped encoding, visible on a single counter bit.

// File: rtl/pcpf_pkg.sv
`timescale 1ns/1ps
package pcpf_pkg;

   localparam int SPLIT_W = 5;

   typedef struct packed {
      logic sec_allow;
      logic mon_split;
      logic mon_cyc_off;
      logic sec_cyc_off;
   } mon_cfg_t;

   typedef struct packed {
      logic [SPLIT_W-1:0] split_pt;
      logic               hi_en;
      logic               lo_el2_off;
      logic               el2_cyc_off;
   } hyp_cfg_t;

   typedef struct packed {
      logic run;
      logic cyc_tied;
   } usr_cfg_t;

   typedef enum logic [1:0] {
      MON_BLOCK_ALL = 2'd0,
      MON_ALLOW_ALL = 2'd1,
      MON_BLOCK_LOW = 2'd2
   } mon_mode_e;

   typedef struct packed {
      logic      at_mon;
      logic      at_hyp;
      logic      sec_lower;
      logic      is_sec;
      logic      sec_ok;
      mon_mode_e mon_mode;
   } state_t;

   function automatic mon_mode_e decode_mon(input logic sa, input logic ms);
      unique case ({sa, ms})
         2'b10:   decode_mon = MON_ALLOW_ALL;
         2'b11:   decode_mon = MON_BLOCK_LOW;
         default: decode_mon = MON_BLOCK_ALL;
      endcase
   endfunction

endpackage

// File: rtl/pcpf_cfg_regs.sv
`timescale 1ns/1ps
module pcpf_cfg_regs
   import pcpf_pkg::*;
#(
   parameter int NCNT = 8,
   parameter int DW   = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [1:0]      sel,
   input  logic [DW-1:0]   wdata,
   output mon_cfg_t        mon_q,
   output hyp_cfg_t        hyp_q,
   output usr_cfg_t        usr_q,
   output logic [NCNT-1:0] mask_q
);

   localparam int HI_BIT  = 8;
   localparam int LO_BIT  = 9;
   localparam int HC_BIT  = 10;
   localparam logic [SPLIT_W-1:0] SPLIT_RST = SPLIT_W'(NCNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mon_q  <= '0;
         hyp_q  <= '{split_pt: SPLIT_RST, hi_en: 1'b0, lo_el2_off: 1'b0, el2_cyc_off: 1'b0};
         usr_q  <= '0;
         mask_q <= '0;
      end else if (we) begin
         unique case (sel)
            2'd0: mon_q <= '{sec_allow: wdata[0], mon_split: wdata[1],
                             mon_cyc_off: wdata[2], sec_cyc_off: wdata[3]};
            2'd1: hyp_q <= '{split_pt: wdata[SPLIT_W-1:0], hi_en: wdata[HI_BIT],
                             lo_el2_off: wdata[LO_BIT], el2_cyc_off: wdata[HC_BIT]};
            2'd2: usr_q <= '{run: wdata[0], cyc_tied: wdata[1]};
            default: mask_q <= wdata[NCNT-1:0];
         endcase
      end
   end

endmodule

// File: rtl/pcpf_state_decode.sv
`timescale 1ns/1ps
module pcpf_state_decode
   import pcpf_pkg::*;
(
   input  logic [1:0] cur_el,
   input  logic       in_secure,
   input  mon_cfg_t   mon,
   input  hyp_cfg_t   hyp,
   output state_t     st,
   output logic       low_block
);

   always_comb begin
      st.at_mon    = (cur_el == 2'd3);
      st.at_hyp    = (cur_el == 2'd2);
      st.is_sec    = in_secure;
      st.sec_lower = in_secure && (cur_el != 2'd3);
      st.sec_ok    = mon.sec_allow | mon.mon_split;
      st.mon_mode  = decode_mon(mon.sec_allow, mon.mon_split);
      low_block    = (st.at_mon && (st.mon_mode != MON_ALLOW_ALL))
                   | (st.sec_lower && !st.sec_ok)
                   | (st.at_hyp && hyp.lo_el2_off);
   end

endmodule

// File: rtl/pcpf_evt_lane.sv
`timescale 1ns/1ps
module pcpf_evt_lane
   import pcpf_pkg::*;
#(
   parameter int IDX = 0
) (
   input  state_t   st,
   input  hyp_cfg_t hyp,
   input  logic     run,
   input  logic     mask_bit,
   output logic     en
);

   localparam logic [SPLIT_W-1:0] IDX_C = SPLIT_W'(IDX);

   logic is_low, hi_blk, mon_blk, sec_blk, hyp_blk;

   always_comb begin
      is_low  = (IDX_C < hyp.split_pt);
      hi_blk  = !is_low && !hyp.hi_en;
      mon_blk = st.at_mon && ((st.mon_mode == MON_BLOCK_ALL) ||
                              ((st.mon_mode == MON_BLOCK_LOW) && is_low));
      sec_blk = st.sec_lower && !st.sec_ok;
      hyp_blk = st.at_hyp && is_low && hyp.lo_el2_off;
      en      = run && mask_bit && !(hi_blk || mon_blk || sec_blk || hyp_blk);
   end

endmodule

// File: rtl/perf_cnt_gate.sv
`timescale 1ns/1ps
module perf_cnt_gate
   import pcpf_pkg::*;
#(
   parameter int NCNT = 8,
   parameter int DW   = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_sel,
   input  logic [DW-1:0]   cfg_wdata,
   input  logic [1:0]      cur_el,
   input  logic            in_secure,
   output logic [NCNT-1:0] evt_en,
   output logic            cyc_en
);

   if (NCNT < 1 || NCNT > 31) begin : g_bad_ncnt
      $error("perf_cnt_gate: NCNT must lie in 1..31");
   end
   if (DW < 11 || DW < NCNT) begin : g_bad_dw
      $error("perf_cnt_gate: DW too narrow for the register fields");
   end

   mon_cfg_t        mon_q;
   hyp_cfg_t        hyp_q;
   usr_cfg_t        usr_q;
   logic [NCNT-1:0] mask_q;
   state_t          st;
   logic            low_block;

   pcpf_cfg_regs #(.NCNT(NCNT), .DW(DW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .mon_q  (mon_q),
      .hyp_q  (hyp_q),
      .usr_q  (usr_q),
      .mask_q (mask_q)
   );

   pcpf_state_decode u_dec (
      .cur_el    (cur_el),
      .in_secure (in_secure),
      .mon       (mon_q),
      .hyp       (hyp_q),
      .st        (st),
      .low_block (low_block)
   );

   for (genvar i = 0; i < NCNT; i++) begin : g_lane
      pcpf_evt_lane #(.IDX(i)) u_lane (
         .st       (st),
         .hyp      (hyp_q),
         .run      (usr_q.run),
         .mask_bit (mask_q[i]),
         .en       (evt_en[i])
      );
   end

   always_comb begin
      cyc_en = usr_q.run
             && !(st.at_mon && mon_q.mon_cyc_off)
             && !(st.is_sec && mon_q.sec_cyc_off)
             && !(st.at_hyp && hyp_q.el2_cyc_off)
             && !(usr_q.cyc_tied && low_block);
   end

endmodule

// File: rtl/pcpf_chk.sv
`timescale 1ns/1ps
module pcpf_chk
   import pcpf_pkg::*;
#(
   parameter int NCNT = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      cur_el,
   input logic            in_secure,
   input logic [NCNT-1:0] evt_en,
   input logic            cyc_en,
   input mon_cfg_t        mon_q,
   input hyp_cfg_t        hyp_q,
   input usr_cfg_t        usr_q,
   input logic [NCNT-1:0] mask_q
);

   assert_run_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !usr_q.run |-> (evt_en == '0 && !cyc_en));

   assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_en & ~mask_q) == '0);

   assert_secure_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_secure && cur_el != 2'd3 && !mon_q.sec_allow && !mon_q.mon_split) |-> evt_en == '0);

   assert_monitor_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_el == 2'd3 && !mon_q.sec_allow) |-> evt_en == '0);

   assert_high_group_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hyp_q.split_pt == '0 && !hyp_q.hi_en) |-> evt_en == '0);

   assert_monitor_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_el == 2'd3 && mon_q.mon_cyc_off) |-> !cyc_en);

endmodule

bind perf_cnt_gate pcpf_chk #(.NCNT(NCNT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cur_el    (cur_el),
   .in_secure (in_secure),
   .evt_en    (evt_en),
   .cyc_en    (cyc_en),
   .mon_q     (mon_q),
   .hyp_q     (hyp_q),
   .usr_q     (usr_q),
   .mask_q    (mask_q)
);

// File: tb/perf_cnt_gate_test.sv
`timescale 1ns/1ps
module perf_cnt_gate_test;

   localparam int N  = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic [1:0]    cur_el = '0;
   logic          in_secure = 1'b0;
   logic [N-1:0]  evt_en;
   logic          cyc_en;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // model of written settings
   bit m_sa, m_ms, m_mc, m_sc, m_hi, m_lo, m_hc, m_run, m_tie;
   int unsigned m_split;
   logic [N-1:0] m_mask;

   always #4 clk = ~clk;

   perf_cnt_gate #(.NCNT(N), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cur_el(cur_el), .in_secure(in_secure),
      .evt_en(evt_en), .cyc_en(cyc_en)
   );

   function automatic bit low_state_block();
      bit b = 1'b0;
      if (cur_el == 2'd3 && !(m_sa && !m_ms)) b = 1'b1;
      if (in_secure && cur_el != 2'd3 && !(m_sa || m_ms)) b = 1'b1;
      if (cur_el == 2'd2 && m_lo) b = 1'b1;
      return b;
   endfunction

   function automatic logic [N-1:0] exp_evt();
      logic [N-1:0] v = '0;
      for (int i = 0; i < N; i++) begin
         bit low = (i < m_split);
         bit ok  = m_run && m_mask[i];
         if (!low && !m_hi) ok = 1'b0;
         if (cur_el == 2'd3) begin
            if (!m_sa) ok = 1'b0;
            else if (m_ms && low) ok = 1'b0;
         end
         if (in_secure && cur_el != 2'd3 && !(m_sa || m_ms)) ok = 1'b0;
         if (cur_el == 2'd2 && low && m_lo) ok = 1'b0;
         v[i] = ok;
      end
      return v;
   endfunction

   function automatic bit exp_cyc();
      bit ok = m_run;
      if (cur_el == 2'd3 && m_mc) ok = 1'b0;
      if (in_secure && m_sc) ok = 1'b0;
      if (cur_el == 2'd2 && m_hc) ok = 1'b0;
      if (m_tie && low_state_block()) ok = 1'b0;
      return ok;
   endfunction

   task automatic wr(input int sel, input logic [DW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         0: begin m_sa = d[0]; m_ms = d[1]; m_mc = d[2]; m_sc = d[3]; end
         1: begin m_split = d[4:0]; m_hi = d[8]; m_lo = d[9]; m_hc = d[10]; end
         2: begin m_run = d[0]; m_tie = d[1]; end
         default: m_mask = d[N-1:0];
      endcase
   endtask

   task automatic check(input string tag, input int el, input bit sec);
      logic [N-1:0] ee;
      bit ec;
      cur_el = 2'(el); in_secure = sec;
      #1;
      ee = exp_evt(); ec = exp_cyc();
      total++;
      if (evt_en !== ee || cyc_en !== ec) begin
         bad++;
         $display("FAIL %s el=%0d sec=%0d evt=%b/%b exp evt=%b/%b", tag, el, sec,
                  evt_en, cyc_en, ee, ec);
      end
   endtask

   function automatic logic [DW-1:0] hyp_word(int split, bit hi, bit lo, bit hc);
      logic [DW-1:0] w = '0;
      w[4:0] = 5'(split); w[8] = hi; w[9] = lo; w[10] = hc;
      return w;
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      m_sa = 0; m_ms = 0; m_mc = 0; m_sc = 0; m_hi = 0; m_lo = 0; m_hc = 0;
      m_run = 0; m_tie = 0; m_split = N; m_mask = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", 0, 0);
      check("R1", 3, 1);

      // R1 split point resets to N: enable hi group off, all low
      wr(3, 32'hFF); wr(0, 32'h1); wr(2, 32'h1);
      check("R1", 1, 0);

      // R2: run off blocks everything
      wr(1, hyp_word(4, 1, 0, 0));
      wr(2, 32'h0);
      check("R2", 0, 0);
      wr(2, 32'h1);
      check("R2", 0, 0);

      // R3 and R10: mask then other register write keeps mask
      wr(3, 32'h5A);
      wr(2, 32'h1);
      check("R3", 1, 0);
      check("R10", 0, 0);

      // R4: secure lower levels
      wr(3, 32'hFF);
      wr(0, 32'h0); check("R4", 1, 1);
      wr(0, 32'h2); check("R4", 0, 1);
      wr(0, 32'h1); check("R4", 2, 1);

      // R5: monitor encodings with split 3
      wr(1, hyp_word(3, 1, 0, 0));
      for (int e = 0; e < 4; e++) begin
         wr(0, DW'(e));
         check("R5", 3, 1);
      end

      // R6: split boundaries
      wr(0, 32'h1);
      wr(1, hyp_word(0, 0, 0, 0)); check("R6", 1, 0);
      wr(1, hyp_word(0, 1, 0, 0)); check("R6", 1, 0);
      wr(1, hyp_word(N - 1, 0, 0, 0)); check("R6", 0, 0);
      wr(1, hyp_word(20, 0, 0, 0)); check("R6", 0, 0);

      // R7: hypervisor low group
      wr(1, hyp_word(5, 1, 1, 0));
      check("R7", 2, 0);
      check("R7", 1, 0);

      // R8: cycle prohibitions
      wr(0, 32'h5); check("R8", 3, 0); check("R8", 1, 0);
      wr(0, 32'h9); check("R8", 1, 1); check("R8", 1, 0);
      wr(1, hyp_word(5, 1, 0, 1)); check("R8", 2, 0);

      // R9: cycle tied to event prohibition
      wr(1, hyp_word(5, 1, 0, 0));
      wr(2, 32'h3);
      wr(0, 32'h3); check("R9", 3, 0);
      wr(0, 32'h1); check("R9", 3, 0);
      wr(0, 32'h0); check("R9", 1, 1); check("R9", 1, 0);

      // random mix
      for (int k = 0; k < 600; k++) begin
         int sel = $urandom_range(0, 3);
         logic [DW-1:0] d = $urandom;
         if (sel == 1) d[4:0] = 5'($urandom_range(0, N + 2));
         if (sel == 2 && ($urandom_range(0, 3) != 0)) d[0] = 1'b1;
         wr(sel, d);
         check("R10", $urandom_range(0, 3), 1'($urandom_range(0, 1)));
         check("R10", $urandom_range(0, 3), 1'($urandom_range(0, 1)));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule